// File: doc/BRIEF.md
# Bus Trace Event Trigger

This block is a single programmable trigger-event detector inside a bus trace and debug unit. Each cycle it checks the current bus transaction and two side sources against a 32-bit configuration word. It then decides whether the programmed condition holds. The bus sources are the transaction's address-trap hits, its requester, data and responder IDs, and its direction. The side sources are an interrupt-trace request and an external active-low debug pin. The address trap comparators sit outside the block, and their hit bits arrive as inputs.

An eight-bit occurrence counter can hold back the event until the condition has been seen a programmed number of extra times. When the event fires, the counter reloads itself. The event leaves the block as a one-cycle pulse to the trigger sequencers. Software writes the configuration word and reads it back. On a read, the top byte shows the live counter.

Top module: `trace_event_trigger`

## Requirements
- R1: After reset, `cfg_rdata` is zero, `event_o` is low, and both one-shot sources are released (not yet fired).
- R2: A write stores the word; reading returns it with bit 8 (reserved) forced to 0 and bits 31:24 showing the live counter. Field positions: [3:0] trap selects, [4] requester-ID enable, [5] data-ID enable, [6] responder-ID enable, [7] interrupt enable, [9] debug-pin enable, [10] write-only, [11] read-only, [15:12] requester ID, [19:16] responder ID, [23:20] data ID, [31:24] count.
- R3: With trap selects all clear the trap hits play no part; with any set, the bus condition needs `trap_hit & selects` to be nonzero.
- R4: With requester-ID matching enabled, the bus condition needs `txn_req_id` equal to bits 15:12.
- R5: With data-ID or responder-ID matching enabled, the bus condition needs `txn_data_id` equal to bits 23:20 or `txn_resp_id` equal to bits 19:16 respectively.
- R6: `txn_write` is 1 for a write and 0 for a read; bit 10 admits only writes, bit 11 only reads, and both together admit nothing.
- R7: The bus condition needs `txn_valid` and at least one of bits 6:0, 10 or 11 set; a word with every source and qualifier clear never produces an event.
- R8: With bit 7 set, the OR of `irq_trace_a` and `irq_trace_b` fires once when it rises and cannot fire again until both inputs have been low for a cycle.
- R9: With bit 9 set, `debug_n` passes through two flip-flops and fires once on its falling edge, re-arming only after it returns high; a low sampled on edge k qualifies the cycle after edge k+1.
- R10: The bus condition, ORed with the two one-shot pulses, is the qualifying condition. In a qualifying cycle with a nonzero counter, the counter decrements and no event is produced. In a qualifying cycle with a zero counter, `event_o` is high for the following cycle only and the counter reloads the written count.
- R11: A write loads both the initial and the live counter, and takes priority: a qualifying cycle that coincides with a write neither counts nor produces an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write word |
| cfg_rdata | output | 32 | Stored configuration with the live counter in 31:24 |
| txn_valid | input | 1 | A bus transaction is present this cycle |
| txn_write | input | 1 | 1 = write transaction, 0 = read |
| trap_hit | input | 4 | Hit flags from the four address trap comparators |
| txn_req_id | input | 4 | Requester ID of the transaction |
| txn_data_id | input | 4 | Data ID of the transaction |
| txn_resp_id | input | 4 | Responder ID of the transaction |
| irq_trace_a | input | 1 | First interrupt-trace request |
| irq_trace_b | input | 1 | Second interrupt-trace request |
| debug_n | input | 1 | Asynchronous active-low debug pin |
| event_o | output | 1 | One-cycle event pulse to the sequencers |

## Verification
Three counter properties are checked on every cycle by assertions: the decrement with no event, the reload with an event one cycle later, and the load on a write. The same holds for the rule that neither one-shot source can pulse in two cycles running. Only the bench's scenarios can show that the bus condition combines the trap, ID and direction terms as programmed. The same goes for the interrupt staying silent while either input is still held, and for the synchroniser's extra cycles of latency on the debug pin. The bench sweeps trap selects against hit patterns, and every programmed ID against every transaction ID. It also runs counts from zero to four under continuous and gapped conditions.

// File: rtl/trace_event_trigger.sv
module trace_event_trigger (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        txn_valid,
  input  logic        txn_write,
  input  logic [3:0]  trap_hit,
  input  logic [3:0]  txn_req_id,
  input  logic [3:0]  txn_data_id,
  input  logic [3:0]  txn_resp_id,
  input  logic        irq_trace_a,
  input  logic        irq_trace_b,
  input  logic        debug_n,
  output logic        event_o
);

  logic [23:0] cfg;
  logic [7:0]  init_cnt, cnt;
  logic        irq_seen, dbg_seen, dbg_s1, dbg_s2;

  wire [3:0] trap_sel  = cfg[3:0];
  wire       req_en    = cfg[4];
  wire       data_en   = cfg[5];
  wire       resp_en   = cfg[6];
  wire       irq_en    = cfg[7];
  wire       dbg_en    = cfg[9];
  wire       wr_only   = cfg[10];
  wire       rd_only   = cfg[11];

  wire bus_armed = |cfg[6:0] | wr_only | rd_only;
  wire addr_ok = (trap_sel == 4'd0 || (trap_sel & trap_hit) != 4'd0) &&
                 (!req_en || txn_req_id == cfg[15:12]);
  wire data_ok = (!data_en || txn_data_id == cfg[23:20]) &&
                 (!resp_en || txn_resp_id == cfg[19:16]);
  wire dir_ok  = (!wr_only || txn_write) && (!rd_only || !txn_write);
  wire bus_cond = bus_armed && txn_valid && addr_ok && data_ok && dir_ok;

  wire irq_any   = irq_trace_a | irq_trace_b;
  wire irq_pulse = irq_en && irq_any && !irq_seen;
  wire dbg_low   = !dbg_s2;
  wire dbg_pulse = dbg_en && dbg_low && !dbg_seen;
  wire cond      = bus_cond | irq_pulse | dbg_pulse;

  assign cfg_rdata = {cnt, cfg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_s1   <= 1'b1;
      dbg_s2   <= 1'b1;
      irq_seen <= 1'b0;
      dbg_seen <= 1'b0;
    end else begin
      dbg_s1   <= debug_n;
      dbg_s2   <= dbg_s1;
      irq_seen <= irq_any;
      dbg_seen <= dbg_low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      init_cnt <= '0;
      cnt      <= '0;
      event_o  <= 1'b0;
    end else if (cfg_we) begin
      cfg      <= cfg_wdata[23:0] & 24'hFF_FEFF;
      init_cnt <= cfg_wdata[31:24];
      cnt      <= cfg_wdata[31:24];
      event_o  <= 1'b0;
    end else if (cond && cnt == 8'd0) begin
      cnt      <= init_cnt;
      event_o  <= 1'b1;
    end else begin
      if (cond) cnt <= cnt - 8'd1;
      event_o  <= 1'b0;
    end
  end

  a_r10_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && cond && cnt != 8'd0) |=> (cnt == $past(cnt) - 8'd1) && !event_o);
  a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && cond && cnt == 8'd0) |=> event_o && cnt == init_cnt);
  a_r11_write_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cnt == $past(cfg_wdata[31:24])) && !event_o);
  a_r8_irq_once: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  a_r9_dbg_once: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_pulse |=> !dbg_pulse);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[8] == 1'b0);

endmodule

// File: tb/trace_event_trigger_bench.sv
module trace_event_trigger_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic txn_valid = 1'b0, txn_write = 1'b0;
  logic [3:0] trap_hit = '0, txn_req_id = '0, txn_data_id = '0, txn_resp_id = '0;
  logic irq_trace_a = 1'b0, irq_trace_b = 1'b0, debug_n = 1'b1;
  logic event_o;

  int checks = 0, errors = 0;
  logic [23:0] m_cfg = '0;
  logic [7:0]  m_init = '0, m_cnt = '0;
  logic m_irq_seen = 0, m_dbg_seen = 0, m_s1 = 1, m_s2 = 1, exp_evt = 0;

  always #2 clk = ~clk;

  trace_event_trigger u_trace_event_trigger (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    logic armed, pa, pd, bus, ia, ip, dl, dp, cond;
    armed = (|m_cfg[6:0]) | m_cfg[10] | m_cfg[11];
    pa = (m_cfg[3:0] == 0 || (m_cfg[3:0] & trap_hit) != 0) &&
         (!m_cfg[4] || txn_req_id == m_cfg[15:12]);
    pd = (!m_cfg[5] || txn_data_id == m_cfg[23:20]) &&
         (!m_cfg[6] || txn_resp_id == m_cfg[19:16]);
    bus = armed && txn_valid && pa && pd &&
          (!m_cfg[10] || txn_write) && (!m_cfg[11] || !txn_write);
    ia = irq_trace_a | irq_trace_b;
    ip = m_cfg[7] && ia && !m_irq_seen;
    dl = !m_s2;
    dp = m_cfg[9] && dl && !m_dbg_seen;
    cond = bus | ip | dp;
    @(posedge clk);
    m_irq_seen = ia; m_dbg_seen = dl; m_s2 = m_s1; m_s1 = debug_n;
    exp_evt = 0;
    if (cfg_we) begin
      m_cfg = cfg_wdata[23:0] & 24'hFF_FEFF;
      m_init = cfg_wdata[31:24]; m_cnt = m_init;
    end else if (cond) begin
      if (m_cnt == 0) begin exp_evt = 1; m_cnt = m_init; end
      else m_cnt = m_cnt - 1;
    end
    @(negedge clk);
    check(tag, {31'd0, event_o}, {31'd0, exp_evt});
    check(tag, cfg_rdata, {m_cnt, m_cfg});
  endtask

  task automatic wcfg(input logic [31:0] w, input string tag);
    cfg_we = 1; cfg_wdata = w; tick(tag); cfg_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rdata", cfg_rdata, 32'd0);
    check("R1 reset event", {31'd0, event_o}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    // R1: one-shots released: an enabled interrupt fires at once
    wcfg(32'h0000_0080, "R1");
    irq_trace_a = 1; tick("R1 irq armed after reset"); tick("R1");
    irq_trace_a = 0; tick("R1");
    // R2: field storage with reserved bit
    wcfg(32'hFFFF_FFFF, "R2 all ones");
    wcfg(32'h00A5_5A00, "R2 pattern");
    // R7: nothing enabled never fires
    wcfg(32'h00FF_F000, "R7");
    for (int i = 0; i < 64; i++) begin
      txn_valid = i[0]; txn_write = i[1]; trap_hit = i[5:2];
      irq_trace_a = i[2]; debug_n = i[3];
      tick("R7 all sources off");
    end
    irq_trace_a = 0; debug_n = 1; tick("R7"); tick("R7");
    // R3: trap selects against hit patterns
    txn_valid = 1;
    for (int s = 0; s < 16; s++) begin
      wcfg({28'd0, s[3:0]} | (s == 0 ? 32'h400 : 32'h0), "R3");
      for (int h = 0; h < 16; h++) begin
        trap_hit = h[3:0]; txn_write = 1; tick("R3 trap select");
      end
    end
    trap_hit = 0;
    // R4: requester ID
    for (int p = 0; p < 16; p++) begin
      wcfg(32'h10 | (p << 12), "R4");
      for (int t = 0; t < 16; t++) begin txn_req_id = t[3:0]; tick("R4 req id"); end
    end
    // R5: data and responder IDs
    for (int p = 0; p < 16; p++) begin
      wcfg(32'h60 | (p << 20) | ((15 - p) << 16), "R5");
      for (int t = 0; t < 16; t++) begin
        txn_data_id = t[3:0]; txn_resp_id = 4'(15 - t); tick("R5 data/resp id");
        txn_resp_id = t[3:0]; tick("R5 resp mismatch");
      end
    end
    // R6: direction qualifiers
    for (int q = 1; q < 4; q++) begin
      wcfg(q << 10, "R6");
      for (int d = 0; d < 4; d++) begin txn_write = d[0]; tick("R6 direction"); end
    end
    // R10: counter under continuous and gapped conditions
    for (int c = 0; c < 5; c++) begin
      wcfg(32'h400 | (c << 24), "R10");
      txn_write = 1;
      for (int k = 0; k < 14; k++) begin txn_valid = 1; tick("R10 continuous"); end
      for (int k = 0; k < 14; k++) begin txn_valid = k[0]; tick("R10 gapped"); end
    end
    // R11: write coincident with a qualifying cycle
    wcfg(32'h0000_0400, "R11");
    txn_valid = 1; txn_write = 1;
    wcfg(32'h0200_0400, "R11 write wins");
    tick("R11"); tick("R11"); tick("R11 reload after write");
    txn_valid = 0;
    // R8: interrupt one-shot
    wcfg(32'h0100_0080, "R8");
    irq_trace_a = 1; tick("R8 rise");
    irq_trace_b = 1; tick("R8 b while a");
    irq_trace_a = 0; tick("R8 b holds");
    irq_trace_a = 1; tick("R8 a again while b");
    irq_trace_a = 0; irq_trace_b = 0; tick("R8 both low");
    irq_trace_b = 1; tick("R8 rearmed");
    irq_trace_b = 0; tick("R8");
    irq_trace_a = 1; tick("R8 second");
    irq_trace_a = 0; tick("R8"); tick("R8");
    // R9: debug pin one-shot through synchroniser
    wcfg(32'h0000_0200, "R9");
    for (int k = 0; k < 24; k++) begin
      debug_n = !(k inside {[2:6], 9, [12:13], 20});
      tick("R9 debug pin");
    end
    debug_n = 1;
    repeat (4) tick("R9 settle");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule